// File: doc/BRIEF.md
# Microcontroller Strobe to FIFO Bridge

This block links the external bus of a slow microcontroller to a FIFO that runs on the fast FPGA clock. The microcontroller's active-low chip select, read strobe and write strobe have no timing relation to the FPGA clock, and a single strobe stays low across many FPGA clock edges. The bridge brings the strobes into the clock domain and finds their edges. It then turns each bus access into exactly one single-cycle FIFO operation, so a long read strobe removes one word and not one word per clock edge.

A read access pops the FIFO on the synchronized falling edge of the read strobe. The popped word goes into a holding register that drives the bus back to the microcontroller. A write access pushes on the synchronized rising edge of the write strobe. The pushed word is the bus value sampled while the strobe was low. A read of an empty FIFO leaves the holding register unchanged. A write to a full FIFO is dropped and raises a sticky overflow flag.

Both FIFO sides use valid/ready. On the pop side the FIFO offers `pop_valid` (not empty) with show-ahead data on `pop_data`, and the bridge raises `pop_ready` for one cycle per read access. A word moves only in a cycle where both are high. On the push side the bridge raises `push_valid` for one cycle per write access. A word moves only if `push_ready` is high in that cycle. The bridge does not stall: the bus cycle is already over, so there is nothing to hold a word for. An offer that finds `push_ready` low is discarded and recorded in `overflow`.

Top module: `mcu_fifo_bridge`

## Requirements
- R1: After reset `pop_ready`, `push_valid` and `overflow` are 0, and the holding register is 0. A read of an empty FIFO right after reset therefore returns 0.
- R2: A read access (`mcu_rd_n` low while `mcu_cs_n` is low) of any length of three FPGA cycles or more causes exactly one `pop_ready` pulse, one cycle wide. The pulse comes no later than SYNC_STAGES+1 cycles after the strobe falls.
- R3: When `pop_ready` and `pop_valid` are high in the same cycle, the holding register loads `pop_data`. The new value is on `mcu_rdata` before the strobe rises. If `pop_valid` is low, no word moves and the holding register keeps its previous value.
- R4: A write access causes exactly one `push_valid` pulse, one cycle wide, after the strobe rises. `push_data` carries the value `mcu_wdata` held while the strobe was low, even if the bus changes in the same instant that the strobe is released.
- R5: If `push_ready` is low during the `push_valid` pulse, the word is dropped and `overflow` becomes 1. `overflow` then stays 1 until reset, and later accepted writes do not clear it.
- R6: `mcu_rdata_oe` is 1 exactly when `mcu_cs_n` and `mcu_rd_n` are both low. `mcu_rdata` carries the holding register while `mcu_rdata_oe` is 1 and is 0 otherwise.
- R7: Strobes given while `mcu_cs_n` is high cause no `pop_ready` and no `push_valid` pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | FPGA clock; the FIFO runs on this clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mcu_cs_n | input | 1 | Microcontroller chip select, active low, asynchronous |
| mcu_rd_n | input | 1 | Microcontroller read strobe, active low, asynchronous |
| mcu_wr_n | input | 1 | Microcontroller write strobe, active low, asynchronous |
| mcu_wdata | input | DATA_W | Write data from the microcontroller bus |
| mcu_rdata | output | DATA_W | Held read data toward the microcontroller bus |
| mcu_rdata_oe | output | 1 | Output enable for the read-data bus driver |
| pop_ready | output | 1 | One-cycle pop request to the FIFO |
| pop_valid | input | 1 | FIFO holds at least one word |
| pop_data | input | DATA_W | Show-ahead head word of the FIFO |
| push_valid | output | 1 | One-cycle push offer to the FIFO |
| push_ready | input | 1 | FIFO has room for a word |
| push_data | output | DATA_W | Word offered to the FIFO |
| overflow | output | 1 | Sticky flag: a write was dropped because the FIFO was full |

## Verification
Read and write strobes are swept over a range of lengths. A design that follows the strobe level pops or pushes more than once per access, and the exact per-access counts show this. Write data is changed in the same instant the strobe is released, which separates a design that samples the bus during the strobe from one that samples after the edge. All four combinations of chip select and read strobe are driven to check the output enable. An empty read, accesses with chip select high, and a write into a full FIFO followed by a good write show the hold, ignore, drop and sticky-flag behaviour at the ports.

// File: rtl/mfb_pkg.sv
package mfb_pkg;
  typedef enum logic {EDGE_FALL = 1'b0, EDGE_RISE = 1'b1} edge_kind_e;

  localparam int STROBE_BITS = 3;
  localparam int CS_BIT = 0;
  localparam int RD_BIT = 1;
  localparam int WR_BIT = 2;
  localparam logic [STROBE_BITS-1:0] STROBE_IDLE = '1;
endpackage

// File: rtl/mfb_delay_line.sv
module mfb_delay_line #(
  parameter int WIDTH = 1,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[i] <= RST_VAL;
        else        stage_q[i] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[i] <= RST_VAL;
        else        stage_q[i] <= stage_q[i-1];
      end
    end
  end

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/mfb_edge.sv
module mfb_edge
  import mfb_pkg::*;
#(
  parameter edge_kind_e KIND = EDGE_FALL,
  parameter logic RST_LEVEL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  output logic pulse
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= RST_LEVEL;
    else        prev_q <= level;
  end

  if (KIND == EDGE_RISE) begin : g_rise
    assign pulse = level & ~prev_q;
  end else begin : g_fall
    assign pulse = ~level & prev_q;
  end
endmodule

// File: rtl/mfb_read_path.sv
module mfb_read_path
  import mfb_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_s,
  input  logic              rd_s,
  input  logic              pop_valid,
  input  logic [DATA_W-1:0] pop_data,
  output logic              pop_ready,
  output logic [DATA_W-1:0] hold_q
);
  logic rd_fall;

  mfb_edge #(.KIND(EDGE_FALL), .RST_LEVEL(1'b1)) rd_edge_i (
    .clk   (clk),
    .rst_n (rst_n),
    .level (rd_s),
    .pulse (rd_fall)
  );

  assign pop_ready = rd_fall & ~cs_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       hold_q <= '0;
    else if (pop_ready && pop_valid)  hold_q <= pop_data;
  end

  // R2: one pop request per access, never two cycles in a row
  assert_pop_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pop_ready |=> !pop_ready);

  // R7: a pop request only while the synchronized chip select is active
  assert_pop_needs_cs_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pop_ready |-> !cs_s);

  // R3: holding register moves only on an accepted pop
  assert_hold_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(pop_ready && pop_valid) |=> $stable(hold_q));
endmodule

// File: rtl/mfb_write_path.sv
module mfb_write_path
  import mfb_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_s,
  input  logic              wr_s,
  input  logic [DATA_W-1:0] wdata_d,
  input  logic              push_ready,
  output logic              push_valid,
  output logic [DATA_W-1:0] push_data,
  output logic              overflow
);
  logic wr_rise;
  logic sel_q;
  logic [DATA_W-1:0] cap_q;
  logic ovf_q;

  mfb_edge #(.KIND(EDGE_RISE), .RST_LEVEL(1'b1)) wr_edge_i (
    .clk   (clk),
    .rst_n (rst_n),
    .level (wr_s),
    .pulse (wr_rise)
  );

  // remember that chip select was active during the strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               sel_q <= 1'b0;
    else if (wr_rise)         sel_q <= 1'b0;
    else if (!wr_s && !cs_s)  sel_q <= 1'b1;
  end

  // sample the delayed bus only while the delayed strobe is low
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cap_q <= '0;
    else if (!wr_s) cap_q <= wdata_d;
  end

  assign push_valid = wr_rise & sel_q;
  assign push_data  = cap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         ovf_q <= 1'b0;
    else if (push_valid && !push_ready) ovf_q <= 1'b1;
  end

  assign overflow = ovf_q;

  // R4: one push offer per access
  assert_push_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    push_valid |=> !push_valid);

  // R5: a refused offer raises the flag
  assert_drop_flags_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && !push_ready) |=> overflow);

  // R5: the flag never clears without reset
  assert_overflow_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);
endmodule

// File: rtl/mcu_fifo_bridge.sv
module mcu_fifo_bridge
  import mfb_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mcu_cs_n,
  input  logic              mcu_rd_n,
  input  logic              mcu_wr_n,
  input  logic [DATA_W-1:0] mcu_wdata,
  output logic [DATA_W-1:0] mcu_rdata,
  output logic              mcu_rdata_oe,
  output logic              pop_ready,
  input  logic              pop_valid,
  input  logic [DATA_W-1:0] pop_data,
  output logic              push_valid,
  input  logic              push_ready,
  output logic [DATA_W-1:0] push_data,
  output logic              overflow
);
  logic [STROBE_BITS-1:0] strobe_raw;
  logic [STROBE_BITS-1:0] strobe_s;
  logic [DATA_W-1:0]      wdata_d;
  logic [DATA_W-1:0]      hold_q;

  assign strobe_raw[CS_BIT] = mcu_cs_n;
  assign strobe_raw[RD_BIT] = mcu_rd_n;
  assign strobe_raw[WR_BIT] = mcu_wr_n;

  mfb_delay_line #(
    .WIDTH   (STROBE_BITS),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (STROBE_IDLE)
  ) strobe_sync_i (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (strobe_raw),
    .dout  (strobe_s)
  );

  // data delayed by the same depth so samples line up with the strobe
  mfb_delay_line #(
    .WIDTH   (DATA_W),
    .STAGES  (SYNC_STAGES),
    .RST_VAL ('0)
  ) wdata_delay_i (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (mcu_wdata),
    .dout  (wdata_d)
  );

  mfb_read_path #(.DATA_W(DATA_W)) read_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_s      (strobe_s[CS_BIT]),
    .rd_s      (strobe_s[RD_BIT]),
    .pop_valid (pop_valid),
    .pop_data  (pop_data),
    .pop_ready (pop_ready),
    .hold_q    (hold_q)
  );

  mfb_write_path #(.DATA_W(DATA_W)) write_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_s       (strobe_s[CS_BIT]),
    .wr_s       (strobe_s[WR_BIT]),
    .wdata_d    (wdata_d),
    .push_ready (push_ready),
    .push_valid (push_valid),
    .push_data  (push_data),
    .overflow   (overflow)
  );

  assign mcu_rdata_oe = ~mcu_cs_n & ~mcu_rd_n;
  assign mcu_rdata    = mcu_rdata_oe ? hold_q : '0;
endmodule

// File: tb/mcu_fifo_bridge_tb_top.sv
`timescale 1ns/1ps
module mcu_fifo_bridge_tb_top;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mcu_cs_n = 1'b1, mcu_rd_n = 1'b1, mcu_wr_n = 1'b1;
  logic [DW-1:0] mcu_wdata = '0;
  logic [DW-1:0] mcu_rdata, pop_data, push_data;
  logic mcu_rdata_oe, pop_ready, pop_valid, push_valid, push_ready, overflow;

  always #4 clk = ~clk;

  mcu_fifo_bridge #(.DATA_W(DW), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .mcu_cs_n(mcu_cs_n), .mcu_rd_n(mcu_rd_n),
    .mcu_wr_n(mcu_wr_n), .mcu_wdata(mcu_wdata), .mcu_rdata(mcu_rdata),
    .mcu_rdata_oe(mcu_rdata_oe), .pop_ready(pop_ready), .pop_valid(pop_valid),
    .pop_data(pop_data), .push_valid(push_valid), .push_ready(push_ready),
    .push_data(push_data), .overflow(overflow)
  );

  // FIFO model, show-ahead, depth 16
  logic [DW-1:0] fmem [16];
  int fcount, rp, wp;
  int fcap = 16;
  int pop_cnt, push_cnt, push_offers, pop_offers;
  logic [DW-1:0] last_push;

  assign pop_valid  = (fcount != 0);
  assign pop_data   = fmem[rp];
  assign push_ready = (fcount < fcap);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fcount <= 0; rp <= 0; wp <= 0;
      pop_cnt <= 0; push_cnt <= 0; push_offers <= 0; pop_offers <= 0;
      last_push <= '0;
    end else begin
      if (push_valid) push_offers <= push_offers + 1;
      if (pop_ready)  pop_offers  <= pop_offers + 1;
      if (push_valid && push_ready) begin
        fmem[wp]  <= push_data;
        wp        <= (wp + 1) % 16;
        push_cnt  <= push_cnt + 1;
        last_push <= push_data;
      end
      if (pop_ready && pop_valid) begin
        rp      <= (rp + 1) % 16;
        pop_cnt <= pop_cnt + 1;
      end
      fcount <= fcount + ((push_valid && push_ready) ? 1 : 0)
                       - ((pop_ready && pop_valid) ? 1 : 0);
    end
  end

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_strobe(input logic [DW-1:0] d, input int len, input bit use_cs);
    @(negedge clk);
    mcu_cs_n = !use_cs; mcu_wdata = d; mcu_wr_n = 1'b0;
    repeat (len) @(negedge clk);
    mcu_wr_n = 1'b1; mcu_cs_n = 1'b1; mcu_wdata = ~d;
    repeat (6) @(negedge clk);
  endtask

  task automatic rd_strobe(input int len, input bit use_cs,
                           output logic [DW-1:0] seen, output logic seen_oe);
    @(negedge clk);
    mcu_cs_n = !use_cs; mcu_rd_n = 1'b0;
    repeat (len) @(negedge clk);
    seen = mcu_rdata; seen_oe = mcu_rdata_oe;
    mcu_rd_n = 1'b1; mcu_cs_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] seen;
    logic seen_oe;
    int p0, q0;
    logic [DW-1:0] exp_word;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1: reset state
    check(pop_ready == 1'b0, "R1 pop_ready", pop_ready, 0);
    check(push_valid == 1'b0, "R1 push_valid", push_valid, 0);
    check(overflow == 1'b0, "R1 overflow", overflow, 0);
    rd_strobe(5, 1'b1, seen, seen_oe);
    check(seen == 8'h00, "R1 hold after reset", seen, 0);
    check(pop_cnt == 0, "R1 empty read no pop", pop_cnt, 0);

    // R6: all combinations of chip select and read strobe
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      mcu_cs_n = c[0]; mcu_rd_n = c[1];
      #1;
      check(mcu_rdata_oe == (!c[0] && !c[1]), "R6 oe", mcu_rdata_oe, (!c[0] && !c[1]));
      check(mcu_rdata == 8'h00, "R6 rdata", mcu_rdata, 0);
      @(negedge clk);
      mcu_cs_n = 1'b1; mcu_rd_n = 1'b1;
      repeat (5) @(negedge clk);
    end

    // R4: writes of many lengths, data changes at release
    for (int len = 3; len <= 10; len++) begin
      p0 = push_cnt;
      exp_word = 8'(8'h40 + len * 3);
      wr_strobe(exp_word, len, 1'b1);
      check(push_cnt == p0 + 1, "R4 one push per write", push_cnt - p0, 1);
      check(last_push == exp_word, "R4 push data", last_push, exp_word);
    end

    // R2/R3: reads of many lengths, one pop each, data in order
    for (int len = 4; len <= 11; len++) begin
      q0 = pop_cnt;
      exp_word = 8'(8'h40 + (len - 1) * 3);
      rd_strobe(len, 1'b1, seen, seen_oe);
      check(pop_cnt == q0 + 1, "R2 one pop per read", pop_cnt - q0, 1);
      check(seen == exp_word, "R3 read data", seen, exp_word);
      check(seen_oe == 1'b1, "R6 oe during read", seen_oe, 1);
    end

    // R3: empty read keeps last value
    q0 = pop_offers;
    rd_strobe(6, 1'b1, seen, seen_oe);
    check(pop_offers == q0 + 1, "R2 pop request on empty", pop_offers - q0, 1);
    check(seen == 8'(8'h40 + 30), "R3 empty read holds", seen, 8'h40 + 30);

    // R7: strobes without chip select
    p0 = push_offers; q0 = pop_offers;
    wr_strobe(8'hA5, 6, 1'b0);
    check(push_offers == p0, "R7 write ignored", push_offers - p0, 0);
    rd_strobe(6, 1'b0, seen, seen_oe);
    check(pop_offers == q0, "R7 read ignored", pop_offers - q0, 0);
    check(seen_oe == 1'b0, "R7 no drive", seen_oe, 0);

    // R5: full FIFO drops and flags, flag sticks
    check(overflow == 1'b0, "R5 flag clear before", overflow, 0);
    fcap = 0;
    p0 = push_cnt; q0 = push_offers;
    wr_strobe(8'h77, 5, 1'b1);
    check(push_offers == q0 + 1, "R5 offer made", push_offers - q0, 1);
    check(push_cnt == p0, "R5 word dropped", push_cnt - p0, 0);
    check(overflow == 1'b1, "R5 flag set", overflow, 1);
    fcap = 16;
    wr_strobe(8'h3C, 5, 1'b1);
    check(push_cnt == p0 + 1, "R5 later write accepted", push_cnt - p0, 1);
    check(overflow == 1'b1, "R5 flag sticky", overflow, 1);
    rd_strobe(5, 1'b1, seen, seen_oe);
    check(seen == 8'h3C, "R3 read after drop", seen, 8'h3C);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule